// File: doc/BRIEF.md
# Overload Hiccup and Thermal Shutdown Controller

This block watches an output power stage and decides, every clock cycle, whether the stage may conduct. An overload comparator and two thermal comparators feed it, and it reports two fault flags. In hiccup (dynamic) mode a detected overload switches the stage off for a long blanking interval. The stage is then switched back on for a short probe interval, one tenth as long by default. If the overload is still there at the end of the probe, the pair of intervals repeats. In clamp (static) mode the stage stays on, because the analog limiter clamps the current, and the overload flag simply mirrors the comparator.

A thermal flag is set by the over-threshold comparator and cleared only by the cool comparator, which gives the shutdown its hysteresis. While the flag is up, thermal shutdown overrides everything else. When it clears, the controller restarts from normal conduction with a fresh timer. Driving the enable low parks the controller in idle with the stage off and the overload flag cleared. Both interval lengths are parameters counted in clock cycles.

States: `ST_IDLE` (disabled), `ST_RUN` (conducting normally), `ST_BLANK` (off interval), `ST_RETRY` (probe interval), `ST_THERM` (thermal shutdown). Transitions: any state → `ST_IDLE` when enable is low; any enabled state → `ST_THERM` while the thermal flag is set; `ST_IDLE`/`ST_THERM` → `ST_RUN`; `ST_RUN` → `ST_BLANK` on overload in hiccup mode; `ST_BLANK` → `ST_RETRY` when the off interval expires; `ST_RETRY` → `ST_BLANK` if overload is present at the probe's last cycle, else → `ST_RUN`; `ST_BLANK`/`ST_RETRY` → `ST_RUN` when clamp mode is selected.

Top module: `ovl_hiccup_ctrl`

## Requirements
- R1: During reset all three outputs are 0; with enable high and no fault, `stage_on_o` is 1 from the second clock edge after reset is released.
- R2: One edge after `en_i` is sampled low, `stage_on_o` and `ovl_flag_o` are 0, and a later enable resumes normal conduction rather than a pending hiccup.
- R3: In hiccup mode (`static_mode_i`=0), an overload sampled while conducting normally drives `stage_on_o` to 0 and `ovl_flag_o` to 1 at the next edge, and the stage stays off for exactly OFF_CYCLES cycles.
- R4: After the off interval the stage is on for exactly ON_CYCLES cycles with `ovl_flag_o` still 1.
- R5: If `ovl_det_i` is 1 at the last cycle of the probe interval, a new off interval of OFF_CYCLES cycles starts.
- R6: If `ovl_det_i` is 0 at the last cycle of the probe interval, normal conduction resumes and `ovl_flag_o` returns to 0.
- R7: During the off interval and the earlier probe cycles, the value of `ovl_det_i` has no effect on the output timing.
- R8: In clamp mode (`static_mode_i`=1) with no thermal fault, `stage_on_o` stays 1 and `ovl_flag_o` equals `ovl_det_i` as sampled at the previous edge.
- R9: Selecting clamp mode during an off or probe interval returns the stage to conduction at the next edge.
- R10: `hot_flag_o` is set one edge after `hot_i` is sampled 1 and stays set until `cool_i` is sampled 1 while `hot_i` is 0; `hot_i` wins when both are 1.
- R11: While `hot_flag_o` is 1, `stage_on_o` is 0 at the next edge and `ovl_flag_o` is 0; after the flag clears the controller resumes normal conduction with the interval timer restarted.
- R12: The thermal flag follows its comparators even while enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the output stage |
| static_mode_i | input | 1 | 1 = clamp mode, 0 = hiccup mode |
| ovl_det_i | input | 1 | Overload comparator output |
| hot_i | input | 1 | Over-temperature comparator (trip point) |
| cool_i | input | 1 | Cool comparator (recovery point) |
| stage_on_o | output | 1 | Output stage enable |
| ovl_flag_o | output | 1 | Overload fault flag |
| hot_flag_o | output | 1 | Over-temperature fault flag |

## Verification
The hardest condition to reach is the probe interval's last cycle, because only there does the overload input decide between another blanking interval and recovery. Neither the state nor the timer is visible at the ports. The bench therefore measures where each probe begins from the rising edge of `stage_on_o`. It then counts forward to place the removal of the overload on the deciding cycle in one run and one cycle later in another. The same approach places thermal trips and clamp-mode switches inside a blanking interval that is in progress.

// File: rtl/ohc_pkg.sv
package ohc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLANK = 3'd2,
        ST_RETRY = 3'd3,
        ST_THERM = 3'd4
    } ohc_state_t;

endpackage

// File: rtl/ohc_thermal.sv
module ohc_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic cool_i,
    output logic hot_flag_o
);

    logic hot_q;

    // Trip dominates recovery; the flag holds between the two thresholds.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (hot_i) begin
            hot_q <= 1'b1;
        end else if (cool_i) begin
            hot_q <= 1'b0;
        end
    end

    assign hot_flag_o = hot_q;

endmodule

// File: rtl/ohc_timer.sv
module ohc_timer #(
    parameter int OFF_CYCLES = 180_000_000,
    parameter int ON_CYCLES  = OFF_CYCLES / 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic load_off_i,
    input  logic load_on_i,
    output logic expired_o
);

    localparam int MAX_CYC = (OFF_CYCLES > ON_CYCLES) ? OFF_CYCLES : ON_CYCLES;
    localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (clr_i) begin
            remain_q <= '0;
        end else if (load_off_i) begin
            remain_q <= OFF_LAST;
        end else if (load_on_i) begin
            remain_q <= ON_LAST;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired_o = (remain_q == '0);

endmodule

// File: rtl/ohc_fsm.sv
module ohc_fsm
    import ohc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       static_mode_i,
    input  logic       ovl_det_i,
    input  logic       hot_flag_i,
    input  logic       expired_i,
    output logic       clr_o,
    output logic       load_off_o,
    output logic       load_on_o,
    output logic       stage_on_o,
    output logic       ovl_flag_o
);

    ohc_state_t state_q;
    ohc_state_t state_d;
    logic       stage_q;
    logic       flag_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: disable first, then thermal, then the hiccup cycle
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else if (hot_flag_i) begin
            state_d = ST_THERM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RUN;
                ST_THERM: state_d = ST_RUN;
                ST_RUN: begin
                    if (!static_mode_i && ovl_det_i) begin
                        state_d = ST_BLANK;
                    end
                end
                ST_BLANK: begin
                    if (static_mode_i) begin
                        state_d = ST_RUN;
                    end else if (expired_i) begin
                        state_d = ST_RETRY;
                    end
                end
                ST_RETRY: begin
                    if (static_mode_i) begin
                        state_d = ST_RUN;
                    end else if (expired_i) begin
                        state_d = ovl_det_i ? ST_BLANK : ST_RUN;
                    end
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Timer control derived from the transition about to happen
    always_comb begin
        clr_o      = (state_d == ST_IDLE) || (state_d == ST_THERM);
        load_off_o = (state_d == ST_BLANK) && (state_q != ST_BLANK);
        load_on_o  = (state_d == ST_RETRY) && (state_q != ST_RETRY);
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            unique case (state_d)
                ST_RUN: begin
                    stage_q <= 1'b1;
                    flag_q  <= static_mode_i & ovl_det_i;
                end
                ST_BLANK: begin
                    stage_q <= 1'b0;
                    flag_q  <= 1'b1;
                end
                ST_RETRY: begin
                    stage_q <= 1'b1;
                    flag_q  <= 1'b1;
                end
                default: begin
                    stage_q <= 1'b0;
                    flag_q  <= 1'b0;
                end
            endcase
        end
    end

    assign stage_on_o = stage_q;
    assign ovl_flag_o = flag_q;

endmodule

// File: rtl/ovl_hiccup_ctrl.sv
module ovl_hiccup_ctrl #(
    parameter int OFF_CYCLES = 180_000_000,
    parameter int ON_CYCLES  = OFF_CYCLES / 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic static_mode_i,
    input  logic ovl_det_i,
    input  logic hot_i,
    input  logic cool_i,
    output logic stage_on_o,
    output logic ovl_flag_o,
    output logic hot_flag_o
);

    logic hot_flag;
    logic t_clr;
    logic t_load_off;
    logic t_load_on;
    logic t_expired;

    ohc_thermal u_thermal (
        .clk        (clk),
        .rst_n      (rst_n),
        .hot_i      (hot_i),
        .cool_i     (cool_i),
        .hot_flag_o (hot_flag)
    );

    ohc_timer #(
        .OFF_CYCLES (OFF_CYCLES),
        .ON_CYCLES  (ON_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (t_clr),
        .load_off_i (t_load_off),
        .load_on_i  (t_load_on),
        .expired_o  (t_expired)
    );

    ohc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .static_mode_i (static_mode_i),
        .ovl_det_i     (ovl_det_i),
        .hot_flag_i    (hot_flag),
        .expired_i     (t_expired),
        .clr_o         (t_clr),
        .load_off_o    (t_load_off),
        .load_on_o     (t_load_on),
        .stage_on_o    (stage_on_o),
        .ovl_flag_o    (ovl_flag_o)
    );

    assign hot_flag_o = hot_flag;

endmodule

// File: rtl/ovl_hiccup_ctrl_checker.sv
module ovl_hiccup_ctrl_checker #(
    parameter int OFF_CYCLES = 180_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic static_mode_i,
    input logic ovl_det_i,
    input logic hot_i,
    input logic cool_i,
    input logic stage_on_o,
    input logic ovl_flag_o,
    input logic hot_flag_o
);

    localparam int RW = $clog2(OFF_CYCLES + 2) + 1;

    logic [RW-1:0] off_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
        end else if (!stage_on_o && ovl_flag_o) begin
            off_run <= off_run + 1'b1;
        end else begin
            off_run <= '0;
        end
    end

    // R2: disable forces stage off and clears the overload flag
    a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!stage_on_o && !ovl_flag_o));

    // R3: a blanking interval never exceeds its length
    a_r3_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        off_run <= RW'(OFF_CYCLES));

    // R8: clamp mode keeps conducting and mirrors the comparator
    a_r8_clamp_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && static_mode_i && !hot_flag_o)
        |=> (stage_on_o && (ovl_flag_o == $past(ovl_det_i))));

    // R10: trip sets the thermal flag
    a_r10_hot_set: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> hot_flag_o);

    // R10: the flag holds until recovery is signalled
    a_r10_hot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_flag_o && !cool_i) |=> hot_flag_o);

    // R11: thermal shutdown takes the stage off
    a_r11_therm_off: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag_o |=> (!stage_on_o && !ovl_flag_o));

endmodule

bind ovl_hiccup_ctrl ovl_hiccup_ctrl_checker #(
    .OFF_CYCLES (OFF_CYCLES)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .static_mode_i (static_mode_i),
    .ovl_det_i     (ovl_det_i),
    .hot_i         (hot_i),
    .cool_i        (cool_i),
    .stage_on_o    (stage_on_o),
    .ovl_flag_o    (ovl_flag_o),
    .hot_flag_o    (hot_flag_o)
);

// File: tb/ovl_hiccup_ctrl_tb.sv
module ovl_hiccup_ctrl_tb;

    localparam int OFF_C = 30;
    localparam int ON_C  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic stat = 1'b0;
    logic ovl = 1'b0;
    logic hot = 1'b0;
    logic cool = 1'b0;
    logic stage_on;
    logic ovl_flag;
    logic hot_flag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ovl_hiccup_ctrl #(
        .OFF_CYCLES (OFF_C),
        .ON_CYCLES  (ON_C)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en),
        .static_mode_i (stat),
        .ovl_det_i     (ovl),
        .hot_i         (hot),
        .cool_i        (cool),
        .stage_on_o    (stage_on),
        .ovl_flag_o    (ovl_flag),
        .hot_flag_o    (hot_flag)
    );

    // Behavioural reference: phase 0 idle, 1 normal, 2 off, 3 probe, 4 thermal
    int m_phase = 0;
    int m_elapsed = 0;
    bit m_hot = 0;
    bit m_stage = 0;
    bit m_flag = 0;

    always @(posedge clk or negedge rst_n) begin
        bit prev_hot;
        if (!rst_n) begin
            m_phase = 0; m_elapsed = 0; m_hot = 0; m_stage = 0; m_flag = 0;
        end else begin
            prev_hot = m_hot;
            if (hot) m_hot = 1;
            else if (cool) m_hot = 0;
            if (!en) m_phase = 0;
            else if (prev_hot) m_phase = 4;
            else if (m_phase == 0 || m_phase == 4) m_phase = 1;
            else if (m_phase == 1) begin
                if (!stat && ovl) begin m_phase = 2; m_elapsed = 0; end
            end else if (m_phase == 2) begin
                if (stat) m_phase = 1;
                else if (m_elapsed == OFF_C - 1) begin m_phase = 3; m_elapsed = 0; end
                else m_elapsed++;
            end else begin
                if (stat) m_phase = 1;
                else if (m_elapsed == ON_C - 1) begin
                    m_phase = ovl ? 2 : 1; m_elapsed = 0;
                end else m_elapsed++;
            end
            m_stage = (m_phase == 1) || (m_phase == 3);
            m_flag  = (m_phase == 2) || (m_phase == 3) || (m_phase == 1 && stat && ovl);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare with the reference on every cycle, away from the active edge
    always @(negedge clk) begin
        cyc++;
        check(cur_req, "stage_on", stage_on, m_stage);
        check(cur_req, "ovl_flag", ovl_flag, m_flag);
        check(cur_req, "hot_flag", hot_flag, m_hot);
    end

    task automatic summary_and_end();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            summary_and_end();
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts consecutive negedges on which stage_on equals lvl
    task automatic run_len(logic lvl, output int n);
        n = 0;
        while (stage_on == lvl && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        step(3);
        cur_req = "R1";
        check("R1", "reset stage", stage_on, 0);
        check("R1", "reset ovl", ovl_flag, 0);
        check("R1", "reset hot", hot_flag, 0);
        en = 1'b1;
        rst_n = 1'b1;
        step(2);
        check("R1", "stage after release", stage_on, 1);
        step(5);

        // R3 R4 R5: persistent overload in hiccup mode
        cur_req = "R3";
        ovl = 1'b1;
        step(1);
        check("R3", "flag on entry", ovl_flag, 1);
        run_len(1'b0, n);
        check("R3", "off length", n, OFF_C);
        cur_req = "R4";
        check("R4", "flag in probe", ovl_flag, 1);
        run_len(1'b1, n);
        check("R4", "on length", n, ON_C);
        cur_req = "R5";
        run_len(1'b0, n);
        check("R5", "repeat off length", n, OFF_C);

        // R6: overload removed exactly at the deciding probe cycle
        cur_req = "R6";
        step(ON_C - 1);
        ovl = 1'b0;
        step(2);
        check("R6", "flag cleared", ovl_flag, 0);
        check("R6", "stage on", stage_on, 1);
        step(5);

        // R5: overload removed one cycle too late still repeats
        cur_req = "R5";
        ovl = 1'b1;
        step(1);
        ovl = 1'b0;
        run_len(1'b0, n);
        ovl = 1'b1;
        step(ON_C);
        ovl = 1'b0;
        step(1);
        check("R5", "late removal repeats", stage_on, 0);
        run_len(1'b0, n);
        step(ON_C + 2);
        check("R6", "recovers", ovl_flag, 0);

        // R7: overload pulses within off interval and early probe are ignored
        cur_req = "R7";
        ovl = 1'b1;
        step(1);
        ovl = 1'b0;
        for (int i = 0; i < OFF_C; i += 4) begin
            ovl = 1'b1; step(1); ovl = 1'b0; step(1);
        end
        step(OFF_C + 2 * ON_C);
        check("R7", "back to run", stage_on, 1);

        // R8: clamp mode
        cur_req = "R8";
        stat = 1'b1;
        for (int i = 0; i < 12; i++) begin
            ovl = (i % 3) != 0;
            step(1);
        end
        ovl = 1'b1;
        step(2);
        check("R8", "clamp flag", ovl_flag, 1);
        check("R8", "clamp stage", stage_on, 1);
        ovl = 1'b0;
        stat = 1'b0;
        step(3);

        // R9: switch to clamp mid off interval
        cur_req = "R9";
        ovl = 1'b1;
        step(8);
        stat = 1'b1;
        step(1);
        check("R9", "stage resumes", stage_on, 1);
        ovl = 1'b0;
        stat = 1'b0;
        step(3);

        // R10 R11: thermal trip during a hiccup
        cur_req = "R11";
        ovl = 1'b1;
        step(6);
        hot = 1'b1;
        step(1);
        check("R10", "hot set", hot_flag, 1);
        hot = 1'b0;
        ovl = 1'b0;
        step(1);
        check("R11", "stage off", stage_on, 0);
        check("R11", "ovl cleared", ovl_flag, 0);
        step(OFF_C + 5);
        check("R10", "hot held", hot_flag, 1);
        cur_req = "R10";
        hot = 1'b1; cool = 1'b1;
        step(2);
        check("R10", "hot wins", hot_flag, 1);
        hot = 1'b0;
        step(1);
        check("R10", "cooled", hot_flag, 0);
        cool = 1'b0;
        step(1);
        check("R11", "resumes run", stage_on, 1);
        cur_req = "R11";
        ovl = 1'b1;
        step(1);
        run_len(1'b0, n);
        check("R11", "fresh timer", n, OFF_C);
        ovl = 1'b0;
        step(ON_C + 3);

        // R2: disable during hiccup, then re-enable
        cur_req = "R2";
        ovl = 1'b1;
        step(5);
        en = 1'b0;
        ovl = 1'b0;
        step(1);
        check("R2", "stage off", stage_on, 0);
        check("R2", "flag cleared", ovl_flag, 0);
        step(4);

        // R12: thermal flag while disabled
        cur_req = "R12";
        hot = 1'b1;
        step(1);
        hot = 1'b0;
        check("R12", "hot while disabled", hot_flag, 1);
        cool = 1'b1;
        step(1);
        cool = 1'b0;
        check("R12", "cool while disabled", hot_flag, 0);
        cur_req = "R2";
        en = 1'b1;
        step(2);
        check("R2", "re-enable runs", stage_on, 1);
        step(4);

        summary_and_end();
    end

endmodule